// File: doc/BRIEF.md
# Multi-Mode Byte Multiplier

This unit multiplies two 8-bit operands into a 16-bit product. A three-bit mode word chooses how the operand bits are read: each operand can be taken as unsigned or as two's complement, and the product can be returned either as a plain integer or as a fixed-point fraction. In the fractional case each operand is taken to have its binary point just below its top bit.

A start strobe captures the operands and the mode. The product appears together with a single-cycle valid pulse exactly two clock edges later. A new start is accepted on the cycle in which valid is high, so a caller that issues a start every other cycle gets one product every two cycles. A start during the one cycle the unit is busy is dropped. In fractional modes the product is the integer product moved up by one bit, and the bit that falls off the top is returned on a carry output.

Top module: `mult8_unit`

## Requirements
- R1: With `mode_i` = 3'b000 (bit 2 fractional, bit 1 operand A signed, bit 0 operand B signed), `prod_o` is the unsigned product of `opa_i` and `opb_i`.
- R2: With `mode_i` = 3'b011, `prod_o` is the low 16 bits of the two's-complement product of both operands.
- R3: With `mode_i` = 3'b010, A is sign-extended and B is zero-extended before multiplying. With `mode_i` = 3'b001, the roles are swapped, so the result is unsigned A times signed B.
- R4: With `mode_i[2]` = 1, `prod_o` equals the integer product for the same low mode bits shifted left by one, with bit 0 equal to 0.
- R5: In fractional modes `carry_o` equals bit 15 of the unshifted integer product. In integer modes `carry_o` is 0.
- R6: A start accepted at a rising edge raises `valid_o` after the second following edge, for exactly one cycle.
- R7: A start in the cycle right after an accepted start is ignored: it produces no product and no valid pulse. A start in a cycle where `valid_o` is high is accepted.
- R8: `prod_o` and `carry_o` hold their values in every cycle that does not deliver a new result.
- R9: After reset, `valid_o`, `prod_o` and `carry_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication with the present operands and mode |
| mode_i | input | 3 | {fractional, A signed, B signed} |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| prod_o | output | 16 | Product |
| carry_o | output | 1 | Bit shifted out in fractional modes |
| valid_o | output | 1 | One-cycle pulse when a new product is on `prod_o` |

## Verification
A wrong extension bit in the operand stage corrupts the upper product byte whenever the operand's top bit is set. That shows up on the next valid pulse, two edges after the start. A busy flag that is stuck or cleared too early shows up at once as a valid pulse that is missing, late or extra, and the bench counts cycles from each accepted start to catch it. A fractional shift taken from the wrong bit shows up as a carry or a bit-0 mismatch on the first fractional operation. Every start in the busy cycle carries scrambled operands, so a busy flag that fails to reject it produces a product nobody expected.

// File: rtl/mul_pkg.sv
package mul_pkg;
   localparam int MODE_W   = 3;
   localparam int MODE_FRC = 2;
   localparam int MODE_AS  = 1;
   localparam int MODE_BS  = 0;
   typedef enum int {ARR_OPERATOR = 0, ARR_SHIFT_ADD = 1} arr_style_e;
endpackage

// File: rtl/mul_opnd_stage.sv
module mul_opnd_stage
   import mul_pkg::*;
#(
   parameter int OP_W = 8,
   localparam int EW = OP_W + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 load_i,
   input  logic [MODE_W-1:0]    mode_i,
   input  logic [OP_W-1:0]      opa_i,
   input  logic [OP_W-1:0]      opb_i,
   output logic signed [EW-1:0] xa_o,
   output logic signed [EW-1:0] xb_o,
   output logic                 frac_o
);
   logic              a_sg, b_sg, swap;
   logic [OP_W-1:0]   sel_a, sel_b;
   logic [EW-1:0]     nx_a, nx_b;

   always_comb begin
      a_sg  = mode_i[MODE_AS];
      b_sg  = mode_i[MODE_BS];
      swap  = b_sg & ~a_sg;
      sel_a = swap ? opb_i : opa_i;
      sel_b = swap ? opa_i : opb_i;
      nx_a  = {(a_sg | b_sg) & sel_a[OP_W-1], sel_a};
      nx_b  = {a_sg & b_sg & sel_b[OP_W-1], sel_b};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         xa_o   <= '0;
         xb_o   <= '0;
         frac_o <= 1'b0;
      end else if (load_i) begin
         xa_o   <= nx_a;
         xb_o   <= nx_b;
         frac_o <= mode_i[MODE_FRC];
      end
   end
endmodule

// File: rtl/mul_array.sv
module mul_array
   import mul_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int STYLE = ARR_OPERATOR,
   localparam int EW = OP_W + 1,
   localparam int XW = 2 * EW,
   localparam int PW = 2 * OP_W
) (
   input  logic signed [EW-1:0] xa_i,
   input  logic signed [EW-1:0] xb_i,
   output logic [PW-1:0]        prod_o
);
   logic signed [XW-1:0] ax, full;
   assign ax = XW'(xa_i);

   if (STYLE == ARR_OPERATOR) begin : g_op
      logic signed [XW-1:0] bx;
      assign bx   = XW'(xb_i);
      assign full = ax * bx;
   end else begin : g_sa
      always_comb begin
         full = '0;
         for (int i = 0; i < EW; i++) begin
            if (xb_i[i]) begin
               if (i == EW - 1) full = full - (ax <<< i);
               else             full = full + (ax <<< i);
            end
         end
      end
   end

   assign prod_o = full[PW-1:0];
endmodule

// File: rtl/mul_out_stage.sv
module mul_out_stage #(
   parameter int OP_W = 8,
   localparam int PW = 2 * OP_W
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic          frac_i,
   input  logic [PW-1:0] raw_i,
   output logic [PW-1:0] prod_o,
   output logic          carry_o,
   output logic          valid_o
);
   logic [PW-1:0] adj;
   logic          adj_c;

   always_comb begin
      if (frac_i) begin
         adj   = {raw_i[PW-2:0], 1'b0};
         adj_c = raw_i[PW-1];
      end else begin
         adj   = raw_i;
         adj_c = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prod_o  <= '0;
         carry_o <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            prod_o  <= adj;
            carry_o <= adj_c;
         end
      end
   end
endmodule

// File: rtl/mult8_unit.sv
module mult8_unit
   import mul_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int STYLE = ARR_OPERATOR,
   localparam int EW = OP_W + 1,
   localparam int PW = 2 * OP_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [OP_W-1:0]   opa_i,
   input  logic [OP_W-1:0]   opb_i,
   output logic [PW-1:0]     prod_o,
   output logic              carry_o,
   output logic              valid_o
);
   if (OP_W < 2 || OP_W > 32) begin : g_bad_width
      $error("mult8_unit: OP_W must lie in 2..32");
   end
   if (STYLE != ARR_OPERATOR && STYLE != ARR_SHIFT_ADD) begin : g_bad_style
      $error("mult8_unit: unknown STYLE");
   end

   logic                 acc, s1_full, s1_frac;
   logic signed [EW-1:0] xa, xb;
   logic [PW-1:0]        raw;

   assign acc = start_i & ~s1_full;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s1_full <= 1'b0;
      else         s1_full <= acc;
   end

   mul_opnd_stage #(.OP_W(OP_W)) u_opnd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(acc),
      .mode_i(mode_i),
      .opa_i (opa_i),
      .opb_i (opb_i),
      .xa_o  (xa),
      .xb_o  (xb),
      .frac_o(s1_frac)
   );

   mul_array #(.OP_W(OP_W), .STYLE(STYLE)) u_arr (
      .xa_i  (xa),
      .xb_i  (xb),
      .prod_o(raw)
   );

   mul_out_stage #(.OP_W(OP_W)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (s1_full),
      .frac_i (s1_frac),
      .raw_i  (raw),
      .prod_o (prod_o),
      .carry_o(carry_o),
      .valid_o(valid_o)
   );
endmodule

// File: rtl/mult8_unit_chk.sv
module mult8_unit_chk #(
   parameter int PW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          start_i,
   input logic          acc,
   input logic          s1_full,
   input logic          s1_frac,
   input logic [PW-1:0] prod_o,
   input logic          carry_o,
   input logic          valid_o
);
   AST_ACCEPT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |-> ##2 valid_o); // R6
   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o); // R6
   AST_RESTART_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && valid_o) |=> s1_full); // R7
   AST_SINGLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s1_full |=> !s1_full); // R7
   AST_FRAC_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_full && s1_frac) |=> !prod_o[0]); // R4
   AST_INT_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_full && !s1_frac) |=> !carry_o); // R5
   AST_OUTPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !s1_full |=> ($stable(prod_o) && $stable(carry_o))); // R8
endmodule

bind mult8_unit mult8_unit_chk #(.PW(PW)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .start_i(start_i),
   .acc    (acc),
   .s1_full(s1_full),
   .s1_frac(s1_frac),
   .prod_o (prod_o),
   .carry_o(carry_o),
   .valid_o(valid_o)
);

// File: tb/sim_mult8_unit.sv
module sim_mult8_unit;
   typedef struct {
      logic [15:0] prod;
      logic        carry;
      int          cyc;
      logic [2:0]  mode;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [7:0]  opa = '0, opb = '0;
   logic [15:0] prod;
   logic        carry, valid;

   int    checks = 0, fails = 0, cyc = 0;
   bit    done = 1'b0;
   item_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mult8_unit u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .opa_i(opa), .opb_i(opb), .prod_o(prod), .carry_o(carry), .valid_o(valid)
   );

   function automatic string tag_of(logic [2:0] m);
      if (m[2])          return "R4";
      if (m[1:0] == 2'b00) return "R1";
      if (m[1:0] == 2'b11) return "R2";
      return "R3";
   endfunction

   function automatic item_t model(logic [2:0] m, logic [7:0] a, logic [7:0] b);
      item_t it;
      int av, bv, p;
      logic [15:0] lo;
      av = m[1] ? int'($signed(a)) : int'(a);
      bv = m[0] ? int'($signed(b)) : int'(b);
      p  = av * bv;
      lo = p[15:0];
      it.mode = m;
      if (m[2]) begin
         it.prod  = {lo[14:0], 1'b0};
         it.carry = lo[15];
      end else begin
         it.prod  = lo;
         it.carry = 1'b0;
      end
      return it;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Issue one operation; busy cycle carries a scrambled start that must be dropped.
   task automatic issue(logic [2:0] m, logic [7:0] a, logic [7:0] b, bit junk, int idle);
      item_t it;
      @(negedge clk);
      start = 1'b1; mode = m; opa = a; opb = b;
      it = model(m, a, b);
      it.cyc = cyc;
      q.push_back(it);
      @(negedge clk);
      start = junk; mode = m ^ 3'b101; opa = a ^ 8'h5A; opb = ~b;
      for (int k = 0; k < idle; k++) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   // Scoreboard monitor
   initial begin : monitor
      logic [15:0] last_p = '0;
      logic        last_c = 1'b0;
      item_t it;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R6/R7", "valid with no pending start", 1, 0);
            end else begin
               it = q.pop_front();
               check(cyc == it.cyc + 2, "R6", "latency cycles", cyc - it.cyc, 2);
               check(prod == it.prod, tag_of(it.mode), "product", prod, it.prod);
               check(carry == it.carry, "R5", "carry", carry, it.carry);
            end
            last_p = prod;
            last_c = carry;
         end else begin
            check(prod == last_p && carry == last_c, "R8", "hold between results",
                  {15'd0, carry, prod}, {15'd0, last_c, last_p});
         end
      end
   end

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : driver
      logic [7:0] corner[5];
      corner = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
      repeat (3) @(negedge clk);
      // R9: reset state
      check(valid == 1'b0, "R9", "valid after reset", valid, 0);
      check(prod == 16'h0, "R9", "prod after reset", prod, 0);
      check(carry == 1'b0, "R9", "carry after reset", carry, 0);
      rst_n = 1'b1;
      // Boundary operands with idle gaps
      for (int m = 0; m < 8; m++)
         for (int j = 0; j < 5; j++)
            for (int a = 0; a < 256; a++)
               issue(3'(m), 8'(a), corner[j], 1'b0, 1);
      // Dense back-to-back traffic, busy-cycle starts on alternate operations
      for (int m = 0; m < 8; m++)
         for (int j = 0; j < 24; j++)
            for (int a = 0; a < 256; a++)
               issue(3'(m), 8'(a), 8'(j * 11), a[0], 0);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R6", "results left undelivered", q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule